// File: doc/BRIEF.md
# Serial ADC Host Sequencer

This block is the host-side controller for a 10-bit serial converter with an input multiplexer. The converter's chip select is held low permanently. The block keeps in step with the converter through its conversion-status line. The design calls that line SARS (`sars_i`): it is high while a conversion runs and low when a result is waiting. When a start request arrives and SARS is low, the block produces a divided serial clock. On that clock it moves the next channel address out on `di_o` and reads the waiting result from `do_i`. When the tenth result bit is in, it presents the word with a one-cycle valid strobe.

The serial clock keeps running past the result exchange until the address bits and the sampling window have elapsed. It is then parked low so the converter can convert. The block watches for SARS to rise and fall again, which marks the end of that conversion. If SARS has not completed that rise and fall within a fixed number of system clocks, the block raises a one-cycle error pulse and returns to idle. A justification setting is latched with each start request. In left-justified mode the word is returned exactly as it arrived. In right-justified mode the first serial slot is treated as a leading zero.

Inputs are assumed synchronous to `clk_i`.

Top module: `sadc_host_seq`

## Requirements
- R1: While reset is held and directly after it, `sclk_o`, `di_o`, `valid_o` and `err_o` are 0.
- R2: `start_i` is accepted only when the block is idle and `sars_i` is 0. When `sars_i` is 1, a start request produces no serial clock.
- R3: Each serial clock phase, high and low, lasts HALF_DIV system clocks, and `sclk_o` idles low. A transaction has exactly ADDR_W+SAMP_CYC (default 48) serial clock cycles, and then `sclk_o` stays low.
- R4: The channel address is presented on `di_o` MSB first. Bit ADDR_W-1 is valid before the first rising `sclk_o`, and each later bit changes on a falling edge. `di_o` is 0 after the last address bit.
- R5: `do_i` is sampled on rising `sclk_o` edges 1 to DATA_W. The first sample is the bit already on the line when the transaction begins. The word is assembled MSB first. `valid_o` rises in the system cycle in which the tenth rising edge appears on `sclk_o`.
- R6: With `left_just_i`=1 at start, `data_o` equals the ten sampled bits, with the first bit in bit 9.
- R7: With `left_just_i`=0 at start, `data_o[9]` is 0 whatever `do_i` carried in the first slot. `data_o[8:0]` holds the remaining nine bits in arrival order.
- R8: From the end of the sampling window until the block is idle again, `sclk_o` has no edge. In particular it stays low while `sars_i` is high.
- R9: If `sars_i` has not risen and then fallen within TMO_CYC system clocks after the last falling `sclk_o`, `err_o` pulses for one cycle. The pulse comes exactly TMO_CYC clocks after that edge, and the block returns to idle.
- R10: `start_i` and `chan_i` are ignored while a transaction or conversion wait is in progress.
- R11: Every transaction produces exactly one `valid_o` pulse, one system cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a transaction |
| chan_i | input | ADDR_W | Multiplexer address for the next conversion |
| left_just_i | input | 1 | 1: left-justified result, 0: right-justified |
| sars_i | input | 1 | Converter status, high while converting |
| do_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Gated serial clock |
| di_o | output | 1 | Serial address to the converter |
| data_o | output | DATA_W | Assembled result |
| valid_o | output | 1 | One-cycle strobe for `data_o` |
| err_o | output | 1 | One-cycle conversion timeout pulse |

## Verification
The hardest situation to reach from the ports is the conversion timeout. The converter must finish a full exchange and sampling window and then leave SARS stuck high. The bench's converter model has a stuck flag that raises SARS after the window and never lowers it. The bench counts system clocks from the last falling serial clock edge to the error pulse. While SARS is still stuck, the bench also issues a start request to show that a busy converter blocks it. A second request is injected in the middle of a running exchange, and the model's captured address must not change.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_CONV = 2'd2
  } sadc_st_e;
endpackage

// File: rtl/sadc_clkgen.sv
module sadc_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int PW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [PW-1:0] ph_q;
  logic          sclk_q;
  logic          tick;

  assign tick   = en_i && (ph_q == PW'(HALF_DIV - 1));
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else if (!en_i) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      ph_q   <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      ph_q <= ph_q + PW'(1);
    end
  end

  AST_HALF_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$stable(sclk_q)) |-> ($past(ph_q) == PW'(HALF_DIV - 1))); // R3
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              last_i,
  input  logic              left_i,
  input  logic              do_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic [DATA_W-2:0] sr_q;
  logic [DATA_W-1:0] word;

  assign word = {sr_q, do_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (shift_i) sr_q <= word[DATA_W-2:0];
      if (last_i) begin
        valid_o <= 1'b1;
        // right-justified: first slot is a leading zero
        data_o  <= left_i ? word : {1'b0, word[DATA_W-2:0]};
      end
    end
  end

  AST_VALID_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R11
endmodule

// File: rtl/sadc_tmo.sv
module sadc_tmo #(
  parameter int TMO_CYC = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic sars_i,
  output logic done_o,
  output logic hit_o,
  output logic err_o
);
  localparam int CW = $clog2(TMO_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          seen_q;

  assign done_o = arm_i && seen_q && !sars_i;
  assign hit_o  = arm_i && !done_o && (cnt_q == CW'(TMO_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      err_o  <= 1'b0;
    end else if (!arm_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      if (sars_i) seen_q <= 1'b1;
      if (cnt_q != CW'(TMO_CYC)) cnt_q <= cnt_q + CW'(1);
      err_o <= hit_o;
    end
  end

  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R9
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |-> (cnt_q < CW'(TMO_CYC))); // R9
endmodule

// File: rtl/sadc_host_seq.sv
module sadc_host_seq
  import sadc_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int ADDR_W   = 3,
  parameter int SAMP_CYC = 45,
  parameter int HALF_DIV = 2,
  parameter int TMO_CYC  = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] chan_i,
  input  logic              left_just_i,
  input  logic              sars_i,
  input  logic              do_i,
  output logic              sclk_o,
  output logic              di_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int TOT = ADDR_W + SAMP_CYC;
  localparam int RW  = $clog2(TOT + 1);

  sadc_st_e          st_q;
  logic [RW-1:0]     rise_cnt_q;
  logic [ADDR_W-1:0] addr_sr_q;
  logic              di_q;
  logic              left_q;
  logic              rise, fall;
  logic              shift, last;
  logic              done, hit;

  sadc_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (st_q == ST_RUN),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign shift = rise && (rise_cnt_q < RW'(DATA_W));
  assign last  = rise && (rise_cnt_q == RW'(DATA_W - 1));

  sadc_capture #(.DATA_W(DATA_W)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .last_i  (last),
    .left_i  (left_q),
    .do_i    (do_i),
    .data_o  (data_o),
    .valid_o (valid_o)
  );

  sadc_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (st_q == ST_CONV),
    .sars_i (sars_i),
    .done_o (done),
    .hit_o  (hit),
    .err_o  (err_o)
  );

  assign di_o = di_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      rise_cnt_q <= '0;
      addr_sr_q  <= '0;
      di_q       <= 1'b0;
      left_q     <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i && !sars_i) begin
            left_q     <= left_just_i;
            di_q       <= chan_i[ADDR_W-1];
            addr_sr_q  <= chan_i << 1;
            rise_cnt_q <= '0;
            st_q       <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (rise) rise_cnt_q <= rise_cnt_q + RW'(1);
          if (fall) begin
            // next address bit; zeros once the address is drained
            di_q      <= addr_sr_q[ADDR_W-1];
            addr_sr_q <= addr_sr_q << 1;
            if (rise_cnt_q == RW'(TOT)) begin
              di_q <= 1'b0;
              st_q <= ST_CONV;
            end
          end
        end
        ST_CONV: begin
          if (done || hit) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_SCLK_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_RUN) |-> !sclk_o); // R8
  AST_RISE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_cnt_q <= RW'(TOT))); // R3
  AST_START_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && sars_i) |=> (st_q == ST_IDLE)); // R2
  AST_DI_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && rise_cnt_q > RW'(ADDR_W)) |-> !di_o); // R4
  AST_VALID_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (st_q == ST_RUN)); // R5
endmodule

// File: tb/sadc_host_seq_bench.sv
module sadc_host_seq_bench;
  localparam int DATA_W = 10;
  localparam int ADDR_W = 3;
  localparam int TOT    = 48;
  localparam int HALF   = 2;
  localparam int TMO    = 256;
  localparam int NV     = 6;
  // {left, chan[2:0], word[9:0]}
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 3'd5, 10'h3A5},
    {1'b0, 3'd2, 10'h3A5},
    {1'b1, 3'd7, 10'h15A},
    {1'b0, 3'd0, 10'h200},
    {1'b1, 3'd3, 10'h001},
    {1'b0, 3'd6, 10'h2C3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] chan = '0;
  logic left = 1'b0;
  logic sars = 1'b0;
  logic dout = 1'b0;
  logic sclk, di, valid, err;
  logic [DATA_W-1:0] data;

  int n_chk = 0, n_fail = 0;
  int rises = 0, falls = 0, bad_sclk = 0, vcnt = 0;
  logic [ADDR_W-1:0] got_addr = '0;
  logic [DATA_W-1:0] cur_word, next_word;
  logic stuck = 1'b0, conv_go = 1'b0;
  realtime t_r = 0, t_f = 0;
  realtime hi_min = 1e9, hi_max = 0, lo_min = 1e9, lo_max = 0;
  bit meas = 1'b0;

  always #10 clk = ~clk;

  sadc_host_seq u_sadc_host_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_i(chan),
    .left_just_i(left), .sars_i(sars), .do_i(dout), .sclk_o(sclk),
    .di_o(di), .data_o(data), .valid_o(valid), .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // converter model
  always @(posedge sclk) begin
    rises++;
    if (sars) bad_sclk++;
    if (rises <= ADDR_W) got_addr = {got_addr[ADDR_W-2:0], di};
    if (meas && rises > 1) begin
      if ($realtime - t_f < lo_min) lo_min = $realtime - t_f;
      if ($realtime - t_f > lo_max) lo_max = $realtime - t_f;
    end
    t_r = $realtime;
  end

  always @(negedge sclk) begin
    falls++;
    if (meas) begin
      if ($realtime - t_r < hi_min) hi_min = $realtime - t_r;
      if ($realtime - t_r > hi_max) hi_max = $realtime - t_r;
    end
    t_f = $realtime;
    dout = (falls < DATA_W) ? cur_word[DATA_W-1-falls] : 1'b0;
    if (falls == TOT) conv_go = 1'b1;
  end

  always begin
    @(posedge conv_go);
    repeat (2) @(negedge clk);
    sars = 1'b1;
    dout = 1'b0;
    if (!stuck) begin
      repeat (41) @(negedge clk);
      sars = 1'b0;
      cur_word = next_word;
      dout = cur_word[DATA_W-1];
    end
    conv_go = 1'b0;
  end

  always @(negedge clk) if (valid) vcnt++;

  initial begin
    #(20ns * 150000);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  task automatic pulse_start(input logic [ADDR_W-1:0] c, input logic l);
    @(negedge clk);
    chan = c; left = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    cur_word = VEC[0][9:0];
    next_word = VEC[0][9:0];
    dout = cur_word[DATA_W-1];
    repeat (3) @(negedge clk);
    chk("R1 sclk", sclk, 0); chk("R1 di", di, 0);
    chk("R1 valid", valid, 0); chk("R1 err", err, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 post sclk", sclk, 0); chk("R1 post valid", valid, 0);

    for (int i = 0; i < NV; i++) begin
      logic [DATA_W-1:0] w, e;
      int k;
      w = VEC[i][9:0];
      e = VEC[i][13] ? w : {1'b0, w[8:0]};
      next_word = VEC[(i + 1) % NV][9:0];
      rises = 0; falls = 0; vcnt = 0; bad_sclk = 0;
      meas = (i == 0);
      pulse_start(VEC[i][12:10], VEC[i][13]);
      k = 0;
      while (!valid && k < 400) begin @(negedge clk); k++; end
      chk("R5 valid at tenth rise", rises, DATA_W);
      if (VEC[i][13]) chk("R6 left word", data, e);
      else            chk("R7 right word", data, e);
      if (i == 2) pulse_start(3'd1, 1'b0); // R10 mid-run request
      wait (falls == TOT);
      repeat (3) @(negedge clk);
      wait (conv_go == 1'b0);
      repeat (4) @(negedge clk);
      chk("R4 address", got_addr, VEC[i][12:10]);
      chk("R3 sclk cycles", rises, TOT);
      chk("R3 sclk low after", sclk, 0);
      chk("R11 one valid", vcnt, 1);
      chk("R8 no sclk while sars", bad_sclk, 0);
      if (i == 2) chk("R10 no second run", falls, TOT);
    end
    chk("R3 high phase min", int'(hi_min), HALF * 20);
    chk("R3 high phase max", int'(hi_max), HALF * 20);
    chk("R3 low phase min", int'(lo_min), HALF * 20);
    chk("R3 low phase max", int'(lo_max), HALF * 20);

    // R9 timeout with SARS stuck high
    begin
      int n;
      stuck = 1'b1;
      rises = 0; falls = 0;
      pulse_start(3'd4, 1'b1);
      wait (falls == TOT);
      n = 0;
      while (n < TMO + 20) begin
        @(posedge clk); n++;
        @(negedge clk);
        if (err) break;
      end
      chk("R9 timeout cycles", n, TMO);
      @(negedge clk);
      chk("R9 err one cycle", err, 0);
      wait (conv_go == 1'b0);
      // R2: busy converter blocks a start
      rises = 0;
      pulse_start(3'd2, 1'b1);
      repeat (20) @(negedge clk);
      chk("R2 start blocked by sars", rises, 0);
      chk("R2 sclk low", sclk, 0);
      stuck = 1'b0;
      sars = 1'b0;
      cur_word = 10'h2AA;
      dout = cur_word[DATA_W-1];
      rises = 0; falls = 0; vcnt = 0;
      pulse_start(3'd2, 1'b1);
      wait (valid);
      @(negedge clk);
      chk("R9 recovered word", data, 10'h2AA);
      wait (falls == TOT);
      wait (conv_go == 1'b0);
      repeat (4) @(negedge clk);
      chk("R4 address after recover", got_addr, 3'd2);
    end
    finish_run();
  end
endmodule